// File: doc/BRIEF.md
# Register-Mapped SPI Byte Shifter

This block lets host software drive a serial configuration flash one byte at a time. Software sees two 8-bit registers on a simple bus. The control register controls the flash chip-select line directly. It also reports which flash read command has been selected and whether an exchange is running. A write to the data register starts one full-duplex 8-bit SPI exchange. A read of the data register returns the byte captured during the most recent exchange.

The block adds no framing of its own. Software lowers chip select, writes each command, address and data byte through the data register, and polls the busy bit between bytes. It then raises chip select again. Chip select can be driven low only while the programming-enable input is high. Dropping that enable releases chip select at once, but an exchange that has already started is allowed to finish.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the data register reads 0x00. The control register reads chip select high (bit 0 = 1) and not busy (bit 2 = 0). SCK is low and the chip-select output is high.
- R2: A data-register write while idle (address 1) produces exactly 8 rising SCK edges. The exchange lasts 8 × DIV system clocks.
- R3: MOSI carries the written byte MSB first. It changes only while SCK is low and is stable whenever SCK is high.
- R4: MISO is sampled on each rising SCK edge, MSB first. After the exchange, a read of the data register returns the captured byte. That value does not change while the block is idle.
- R5: SCK idles low. While an exchange runs, each SCK phase lasts DIV/2 system clocks, which gives 4 × DIV high clocks per byte.
- R6: A control-register write (address 0) with bit 0 = 1 drives chip select high, and with bit 0 = 0 drives it low. The line changes on the next system clock, and only goes low while prog_en is 1. With prog_en at 0 the line stays high.
- R7: Control-register bit 0 reads back the actual chip-select level, not the last value written.
- R8: Control-register bit 1 reads the read-command type: 1 = standard read, 0 = fast read (taken from std_read_sel).
- R9: Control-register bit 2 reads 1 for the whole exchange. A data-register write that arrives while busy is ignored: the outgoing bits, the captured byte and the length of the exchange are unchanged.
- R10: If prog_en falls while chip select is low, chip select goes high on the next system clock. An exchange in progress still runs to completion with the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| prog_en | input | 1 | Programming-interface enable; gates chip select low |
| std_read_sel | input | 1 | Read-command type: 1 standard, 0 fast |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| xfer_busy | output | 1 | Exchange in progress |

## Verification
The assertions check several properties on every cycle. SCK stays low when idle, and MOSI holds steady while SCK is high. Chip select never goes low without prog_en, and the captured byte never moves while idle. An exchange only starts from an accepted data write. Other behaviours can only be shown by the bench's scenarios, which end-to-end compare the bytes exchanged against a modelled slave. These cover the exact count of clock edges, the phase lengths and the length of the exchange. They also cover the read-back of the chip-select level, a write being dropped while busy, and an exchange that survives a mid-transfer loss of enable.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_DATA = 1'b1
    } reg_addr_e;

    // control-register bit positions
    localparam int unsigned CTRL_CS_BIT     = 0;
    localparam int unsigned CTRL_RDTYPE_BIT = 1;
    localparam int unsigned CTRL_BUSY_BIT   = 2;

    typedef struct packed {
        logic              sel;
        logic              wr;
        reg_addr_e         addr;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic              ctrl_we;
        logic              cs_wbit;
        logic              start;
        logic [BYTE_W-1:0] tx_byte;
    } dec_out_t;

    function automatic logic [BYTE_W-1:0] pack_ctrl(input logic cs_level,
                                                    input logic rd_std,
                                                    input logic busy);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[CTRL_CS_BIT]     = cs_level;
        v[CTRL_RDTYPE_BIT] = rd_std;
        v[CTRL_BUSY_BIT]   = busy;
        return v;
    endfunction

endpackage

// File: rtl/spi_bus_decode.sv
module spi_bus_decode
    import spi_byte_pkg::*;
(
    input  bus_req_t req,
    input  logic     busy,
    output dec_out_t dec
);
    always_comb begin
        dec.ctrl_we = req.sel && req.wr && (req.addr == ADDR_CTRL);
        dec.cs_wbit = req.wdata[CTRL_CS_BIT];
        dec.start   = req.sel && req.wr && (req.addr == ADDR_DATA) && !busy;
        dec.tx_byte = req.wdata;
    end
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_we,
    input  logic cs_wbit,
    input  logic prog_en,
    output logic cs_n
);
    logic cs_req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_req_q <= 1'b1;
            cs_n     <= 1'b1;
        end else begin
            if (ctrl_we)
                cs_req_q <= cs_wbit;
            // low only when requested low and enabled; the effective request
            // uses the incoming write so the line follows on the next clock
            cs_n <= !((ctrl_we ? !cs_wbit : !cs_req_q) && prog_en);
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_byte_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned BW   = $clog2(BYTE_W + 1);

    generate
        if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
            $error("DIV must be an even value of at least 2");
        end
    endgenerate

    logic [CW-1:0]     div_q;
    logic [BW-1:0]     bits_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic              phase_end;

    assign phase_end = (div_q == CW'(HALF - 1));
    assign mosi      = busy ? tx_q[BYTE_W-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            bits_q  <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            rx_byte <= '0;
            sck     <= 1'b0;
            busy    <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                tx_q   <= tx_byte;
                div_q  <= '0;
                bits_q <= '0;
                sck    <= 1'b0;
                busy   <= 1'b1;
            end
        end else if (!phase_end) begin
            div_q <= div_q + 1'b1;
        end else begin
            div_q <= '0;
            if (!sck) begin
                // rising edge: sample MISO
                sck    <= 1'b1;
                rx_q   <= {rx_q[BYTE_W-2:0], miso};
                bits_q <= bits_q + 1'b1;
                if (bits_q == BW'(BYTE_W - 1))
                    rx_byte <= {rx_q[BYTE_W-2:0], miso};
            end else begin
                // falling edge: present next bit or finish
                sck <= 1'b0;
                if (bits_q == BW'(BYTE_W))
                    busy <= 1'b0;
                else
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_byte_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       prog_en,
    input  logic       std_read_sel,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n,
    output logic       xfer_busy
);
    bus_req_t          req;
    dec_out_t          dec;
    logic              data_start;
    logic [BYTE_W-1:0] rx_byte;

    assign req.sel   = bus_sel;
    assign req.wr    = bus_wr;
    assign req.addr  = reg_addr_e'(bus_addr);
    assign req.wdata = bus_wdata;

    spi_bus_decode u_dec (
        .req  (req),
        .busy (xfer_busy),
        .dec  (dec)
    );

    assign data_start = dec.start;

    spi_cs_ctrl u_cs (
        .clk     (clk),
        .rst     (rst),
        .ctrl_we (dec.ctrl_we),
        .cs_wbit (dec.cs_wbit),
        .prog_en (prog_en),
        .cs_n    (spi_cs_n)
    );

    spi_shift_engine #(.DIV(DIV)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (data_start),
        .tx_byte (dec.tx_byte),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (xfer_busy),
        .rx_byte (rx_byte)
    );

    always_comb begin
        case (req.addr)
            ADDR_CTRL: bus_rdata = pack_ctrl(spi_cs_n, std_read_sel, xfer_busy);
            default:   bus_rdata = rx_byte;
        endcase
    end
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       prog_en,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic       xfer_busy,
    input logic       data_start,
    input logic [7:0] rx_byte
);
    // R6 / R10: line never low without enable on the previous clock
    a_r6_cs_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !prog_en |=> spi_cs_n);

    // R5: SCK idles low
    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        !xfer_busy |-> !spi_sck);

    // R3: MOSI steady while SCK high
    a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_mosi));

    // R4: captured byte does not move while idle
    a_r4_rx_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(xfer_busy) |-> $stable(rx_byte));

    // R9: an exchange begins only from an accepted data write
    a_r9_busy_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_busy) |-> $past(data_start));
endmodule

bind spi_byte_port spi_byte_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .prog_en    (prog_en),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi),
    .xfer_busy  (xfer_busy),
    .data_start (data_start),
    .rx_byte    (rx_byte)
);

// File: tb/sim_spi_byte_port.sv
module sim_spi_byte_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       prog_en = 1'b0;
    logic       std_read_sel = 1'b1;
    logic       spi_sck;
    logic       spi_mosi;
    logic       spi_miso;
    logic       spi_cs_n;
    logic       xfer_busy;

    int checks = 0;
    int failures = 0;

    // slave model
    logic [7:0] slave_sh = 8'h00;
    logic [7:0] cap = 8'h00;
    int         rises = 0;

    assign spi_miso = slave_sh[7];

    always @(posedge spi_sck) begin
        cap = {cap[6:0], spi_mosi};
        rises++;
    end
    always @(negedge spi_sck) slave_sh = {slave_sh[6:0], 1'b0};

    always #10 clk = ~clk;   // 50 MHz

    spi_byte_port #(.DIV(4)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prog_en(prog_en), .std_read_sel(std_read_sel), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
        .xfer_busy(xfer_busy)
    );

    // tx byte in [15:8], slave reply in [7:0]
    localparam logic [15:0] VECS [0:5] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00,
                                           16'h81_7E, 16'h5A_C3, 16'h01_80};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sl,
                            output int bcyc, output int highs);
        slave_sh = sl; cap = 8'h00; rises = 0;
        bus_write(1'b1, tx);
        bcyc = 0; highs = 0;
        while (xfer_busy && bcyc < 1000) begin
            bcyc++;
            if (spi_sck) highs++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int bc, hi, cnt;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(1'b1, rd);  check("R1 data reset", rd, 8'h00);
        bus_read(1'b0, rd);  check("R1 ctrl cs bit", rd[0], 1'b1);
        check("R1 ctrl busy bit", rd[2], 1'b0);
        check("R1 sck low", spi_sck, 1'b0);
        check("R1 cs high", spi_cs_n, 1'b1);

        // R8 read-command type
        std_read_sel = 1'b1; bus_read(1'b0, rd); check("R8 standard", rd[1], 1'b1);
        std_read_sel = 1'b0; bus_read(1'b0, rd); check("R8 fast", rd[1], 1'b0);

        // R6/R7: low request without enable
        bus_write(1'b0, 8'h00);
        @(negedge clk);
        check("R6 no enable keeps cs high", spi_cs_n, 1'b1);
        bus_read(1'b0, rd); check("R7 reads actual level", rd[0], 1'b1);
        prog_en = 1'b1;
        @(negedge clk);
        check("R6 enable lowers cs", spi_cs_n, 1'b0);
        bus_read(1'b0, rd); check("R7 reads low level", rd[0], 1'b0);

        // vector table: R2 R3 R4 R5
        for (int i = 0; i < 6; i++) begin
            run_xfer(VECS[i][15:8], VECS[i][7:0], bc, hi);
            check("R3 mosi byte", cap, VECS[i][15:8]);
            check("R2 rising edges", rises, 8);
            check("R2 exchange length", bc, 32);
            check("R5 high clocks", hi, 16);
            bus_read(1'b1, rd); check("R4 captured byte", rd, VECS[i][7:0]);
        end
        repeat (3) @(negedge clk);
        bus_read(1'b1, rd); check("R4 held while idle", rd, VECS[5][7:0]);
        check("R5 sck idle", spi_sck, 1'b0);

        // R9: write during busy ignored
        slave_sh = 8'h96; cap = 8'h00; rises = 0;
        bus_write(1'b1, 8'hA5);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (xfer_busy) cnt++;
            if (k == 6) begin
                bus_read(1'b0, rd); check("R9 busy bit", rd[2], 1'b1);
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h3C;
            end else begin
                bus_sel = 1'b0; bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        check("R9 length unchanged", cnt, 32);
        check("R9 mosi unchanged", cap, 8'hA5);
        check("R9 edges unchanged", rises, 8);
        bus_read(1'b1, rd); check("R9 captured byte", rd, 8'h96);
        bus_read(1'b0, rd); check("R9 busy cleared", rd[2], 1'b0);

        // R10: enable dropped mid-exchange
        slave_sh = 8'h4B; cap = 8'h00; rises = 0;
        bus_write(1'b1, 8'hD2);
        repeat (5) @(negedge clk);
        prog_en = 1'b0;
        @(negedge clk);
        check("R10 cs forced high", spi_cs_n, 1'b1);
        check("R10 still busy", xfer_busy, 1'b1);
        cnt = 0;
        while (xfer_busy && cnt < 1000) begin cnt++; @(negedge clk); end
        check("R10 mosi complete", cap, 8'hD2);
        check("R10 edges complete", rises, 8);
        bus_read(1'b1, rd); check("R10 captured byte", rd, 8'h4B);

        // R6 write 1 raises line
        prog_en = 1'b1;
        @(negedge clk);
        check("R6 re-enable lowers cs", spi_cs_n, 1'b0);
        bus_write(1'b0, 8'h01);
        check("R6 write one raises cs", spi_cs_n, 1'b1);
        bus_read(1'b0, rd); check("R7 reads high", rd[0], 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule